// File: doc/BRIEF.md
# Owner-Tracking Shared Cache Bank

This block is one bank of a shared second-level cache in which the data storage is also the coherence directory. Each word slot has a one-bit ownership flag. When the flag is clear, the slot holds the current data value. When it is set, the low bits of the slot hold the number of the single core that owns the only up-to-date copy. No list of sharers is kept, and there is no separate directory storage. Lines are one word wide.

Cores send one request per cycle: a read, a registration (a claim of ownership) or a writeback. Every request is settled in the cycle it is accepted, with no transient states. One cycle later the bank answers in one of three ways: a data reply, an acknowledgement to the requester, or a forward request to the current owner that names the requester. Private caches may pass copies among themselves without telling the bank, so the bank follows only who owns each word.

Top module: `owner_dir_bank`

## Requirements
- R1: After reset every slot holds data value 0 and is not owned, and `rsp_valid` and `fwd_valid` are low.
- R2: A read (`req_op` = 0) of a slot that is not owned gives, on the next cycle, `rsp_valid`=1, `rsp_ack`=0, `rsp_core` equal to the requester and `rsp_data` equal to the stored word.
- R3: A registration (`req_op` = 1) gives, on the next cycle, `rsp_valid`=1, `rsp_ack`=1 and `rsp_core` equal to the requester. The slot becomes owned by the requester.
- R4: A read of an owned slot gives, on the next cycle, `fwd_valid`=1, `fwd_owner` equal to the owner, `fwd_requester` equal to the reader and `fwd_addr` equal to the slot address. No data reply is sent.
- R5: A writeback (`req_op` = 2) from the owning core stores `req_wdata` and clears ownership, so later reads return that value. A writeback produces no output.
- R6: A writeback from a core that is not the owner, or to a slot that is not owned, is dropped. The slot keeps its contents and its ownership.
- R7: A registration of a slot owned by another core replaces the owner. After that, writebacks from the old owner are dropped.
- R8: A cycle with `req_valid` low, or with `req_op` = 3, produces no output and changes no slot.
- R9: `rsp_valid` and `fwd_valid` are never high in the same cycle. An accepted read produces exactly one of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request kind: 0 read, 1 register, 2 writeback, 3 unused |
| req_core | input | CORE_W | Number of the requesting core |
| req_addr | input | ADDR_W | Word slot address |
| req_wdata | input | DATA_W | Writeback data |
| rsp_valid | output | 1 | Reply to the requester |
| rsp_ack | output | 1 | 1 = registration acknowledgement, 0 = data reply |
| rsp_core | output | CORE_W | Core that receives the reply |
| rsp_data | output | DATA_W | Data for a data reply, zero for an acknowledgement |
| fwd_valid | output | 1 | Forward request to the owner |
| fwd_owner | output | CORE_W | Owner that receives the forward |
| fwd_requester | output | CORE_W | Core waiting for the data |
| fwd_addr | output | ADDR_W | Slot being forwarded |

## Verification
Reads are issued to three kinds of slot: slots still holding their reset value, slots that are owned, and slots whose data has been written back. This separates direct data replies from forward requests, and shows that a writeback really clears the ownership flag. Writebacks come from three sources: the owner, a core that never owned the slot, and a core that lost ownership to a later registration. Only the first source may change the slot, so the three cases separate owner matching from flag checking. Unused opcodes, idle cycles and the highest address are also tried, to show that they leave the stored state untouched.

// File: rtl/owner_dir_bank.sv
module owner_dir_bank #(
  parameter int NUM_CORES = 4,
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 32,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [CORE_W-1:0] req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic [CORE_W-1:0] rsp_core,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fwd_valid,
  output logic [CORE_W-1:0] fwd_owner,
  output logic [CORE_W-1:0] fwd_requester,
  output logic [ADDR_W-1:0] fwd_addr
);
  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_REG  = 2'd1;
  localparam logic [1:0] OP_WB   = 2'd2;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  owned_q;

  logic [DATA_W-1:0] cur_word;
  logic [CORE_W-1:0] cur_owner;
  logic              cur_owned, do_read, do_reg, do_wb;

  assign cur_word  = slot_q[req_addr];
  assign cur_owner = cur_word[CORE_W-1:0];
  assign cur_owned = owned_q[req_addr];
  assign do_read   = req_valid && req_op == OP_READ;
  assign do_reg    = req_valid && req_op == OP_REG;
  assign do_wb     = req_valid && req_op == OP_WB && cur_owned && cur_owner == req_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (do_reg) begin
      owned_q[req_addr] <= 1'b1;
      slot_q[req_addr]  <= DATA_W'(req_core);
    end else if (do_wb) begin
      owned_q[req_addr] <= 1'b0;
      slot_q[req_addr]  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_ack       <= 1'b0;
      rsp_core      <= '0;
      rsp_data      <= '0;
      fwd_valid     <= 1'b0;
      fwd_owner     <= '0;
      fwd_requester <= '0;
      fwd_addr      <= '0;
    end else begin
      rsp_valid     <= (do_read && !cur_owned) || do_reg;
      rsp_ack       <= do_reg;
      rsp_core      <= req_core;
      rsp_data      <= do_reg ? '0 : cur_word;
      fwd_valid     <= do_read && cur_owned;
      fwd_owner     <= cur_owner;
      fwd_requester <= req_core;
      fwd_addr      <= req_addr;
    end
  end
endmodule

module owner_dir_bank_chk #(
  parameter int CORE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [CORE_W-1:0] req_core,
  input logic              rsp_valid,
  input logic              rsp_ack,
  input logic [CORE_W-1:0] rsp_core,
  input logic              fwd_valid,
  input logic [CORE_W-1:0] fwd_requester
);
  p_excl_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && fwd_valid));

  p_read_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |=> (rsp_valid ^ fwd_valid));

  p_reg_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) |=> (rsp_valid && rsp_ack && rsp_core == $past(req_core)));

  p_fwd_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |=> (!fwd_valid || fwd_requester == $past(req_core)));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op == 2'd2 || req_op == 2'd3) |=> (!rsp_valid && !fwd_valid));

  p_data_not_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |=> !rsp_ack);
endmodule

bind owner_dir_bank owner_dir_bank_chk #(.CORE_W(CORE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_core(req_core), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
  .rsp_core(rsp_core), .fwd_valid(fwd_valid), .fwd_requester(fwd_requester)
);

// File: tb/owner_dir_bank_tb.sv
`timescale 1ns/1ps
module owner_dir_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_core = '0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ack, fwd_valid;
  logic [1:0]  rsp_core, fwd_owner, fwd_requester;
  logic [31:0] rsp_data;
  logic [3:0]  fwd_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  owner_dir_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_core(rsp_core), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_owner(fwd_owner), .fwd_requester(fwd_requester),
    .fwd_addr(fwd_addr)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  core;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        e_rsp;
    logic        e_ack;
    logic [31:0] e_data;
    logic        e_fwd;
    logic [1:0]  e_owner;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 4'd3,  32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 2'd0, 4'd1}, // R1 reset content
    '{2'd2, 2'd2, 4'd3,  32'hAA,       1'b0, 1'b0, 32'h0,        1'b0, 2'd0, 4'd6}, // R6 unowned wb
    '{2'd0, 2'd0, 4'd3,  32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 2'd0, 4'd6}, // R6 slot intact
    '{2'd1, 2'd2, 4'd5,  32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 2'd0, 4'd3}, // R3 register
    '{2'd0, 2'd1, 4'd5,  32'h0,        1'b0, 1'b0, 32'h0,        1'b1, 2'd2, 4'd4}, // R4 forward
    '{2'd2, 2'd3, 4'd5,  32'h55,       1'b0, 1'b0, 32'h0,        1'b0, 2'd0, 4'd6}, // R6 non-owner wb
    '{2'd0, 2'd0, 4'd5,  32'h0,        1'b0, 1'b0, 32'h0,        1'b1, 2'd2, 4'd6}, // R6 still owned
    '{2'd1, 2'd3, 4'd5,  32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 2'd0, 4'd7}, // R7 re-register
    '{2'd2, 2'd2, 4'd5,  32'h77,       1'b0, 1'b0, 32'h0,        1'b0, 2'd0, 4'd7}, // R7 old owner wb
    '{2'd0, 2'd1, 4'd5,  32'h0,        1'b0, 1'b0, 32'h0,        1'b1, 2'd3, 4'd7}, // R7 new owner
    '{2'd2, 2'd3, 4'd5,  32'h1234,     1'b0, 1'b0, 32'h0,        1'b0, 2'd0, 4'd5}, // R5 owner wb
    '{2'd0, 2'd2, 4'd5,  32'h0,        1'b1, 1'b0, 32'h1234,     1'b0, 2'd0, 4'd5}, // R5 data back
    '{2'd3, 2'd1, 4'd5,  32'h9,        1'b0, 1'b0, 32'h0,        1'b0, 2'd0, 4'd8}, // R8 op 3
    '{2'd0, 2'd0, 4'd5,  32'h0,        1'b1, 1'b0, 32'h1234,     1'b0, 2'd0, 4'd8}, // R8 no change
    '{2'd1, 2'd1, 4'd15, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 2'd0, 4'd3}, // R3 top addr
    '{2'd2, 2'd1, 4'd15, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0,        1'b0, 2'd0, 4'd5}, // R5 top addr
    '{2'd0, 2'd3, 4'd15, 32'h0,        1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 4'd2}, // R2 full word
    '{2'd0, 2'd0, 4'd0,  32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 2'd0, 4'd2}  // R2 addr 0
  };

  task automatic check(input string tag, input logic [79:0] got, input logic [79:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [79:0] observe();
    logic [79:0] o;
    o = '0;
    o[0] = rsp_valid;
    o[1] = fwd_valid;
    if (rsp_valid) o[39:2] = {rsp_ack, rsp_core, rsp_data, 3'b0};
    if (fwd_valid) o[51:40] = {fwd_owner, fwd_requester, fwd_addr, 4'b0};
    return o;
  endfunction

  function automatic logic [79:0] expect_of(input vec_t v);
    logic [79:0] o;
    o = '0;
    o[0] = v.e_rsp;
    o[1] = v.e_fwd;
    if (v.e_rsp) o[39:2] = {v.e_ack, v.core, v.e_data, 3'b0};
    if (v.e_fwd) o[51:40] = {v.e_owner, v.core, v.addr, 4'b0};
    return o;
  endfunction

  task automatic issue(input logic vld, input logic [1:0] op, input logic [1:0] core,
                       input logic [3:0] addr, input logic [31:0] wd);
    req_valid = vld; req_op = op; req_core = core; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs idle in reset", {78'b0, rsp_valid, fwd_valid}, 80'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs idle after reset", {78'b0, rsp_valid, fwd_valid}, 80'b0);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VECS[i].op, VECS[i].core, VECS[i].addr, VECS[i].wdata);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), observe(), expect_of(VECS[i]));
      check("R9 exclusive outputs", {79'b0, rsp_valid && fwd_valid}, 80'b0);
    end

    // R8: idle cycle with a read opcode does nothing
    issue(1'b0, 2'd0, 2'd1, 4'd5, 32'h0);
    check("R8 idle no output", {78'b0, rsp_valid, fwd_valid}, 80'b0);

    // R7/R4: owner of slot 9 becomes core 0, then core 2 reads it
    issue(1'b1, 2'd1, 2'd1, 4'd9, 32'h0);
    issue(1'b1, 2'd1, 2'd0, 4'd9, 32'h0);
    issue(1'b1, 2'd0, 2'd2, 4'd9, 32'h0);
    check("R7 owner replaced", {68'b0, fwd_valid, fwd_owner, fwd_requester, fwd_addr, rsp_valid},
          {68'b0, 1'b1, 2'd0, 2'd2, 4'd9, 1'b0});

    // R1: reset in mid-run clears ownership and data
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b1, 2'd0, 2'd3, 4'd5, 32'h0);
    check("R1 slot cleared by reset", {46'b0, rsp_valid, fwd_valid, rsp_data},
          {46'b0, 1'b1, 1'b0, 32'h0});
    issue(1'b1, 2'd0, 2'd3, 4'd9, 32'h0);
    check("R1 ownership cleared by reset", {78'b0, rsp_valid, fwd_valid}, {78'b0, 1'b1, 1'b0});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule